// File: doc/BRIEF.md
# I2C Bus Timeout Monitor

This block guards a two-wire serial bus controller against hangs. It keeps the controller's bus-occupied state and watches the synchronized clock line. From these two inputs it raises two kinds of timeout event.

The first is a bus-idle timeout. It fires when the bus is marked occupied but the clock line has stayed high for a programmed number of cycles. The second is a clock-low timeout. It fires when the clock line has been held low for a programmed number of cycles, whatever the data line is doing.

Both counters restart from zero after each expiry and keep going while their condition holds. A stuck bus therefore produces a timeout at a steady rate. Each event sets a sticky flag that software clears by writing one. When automatic idling is enabled, a bus-idle timeout also frees the bus and sends a one-cycle force-idle pulse back to the controller.

Top module: `i2c_tmo_monitor`

## Requirements
- R1: The bus-idle counter advances only in cycles where the bus is occupied, the clock line is high, the bus-idle enable is set and the bus-idle period P is not zero. `idle_flag_o` rises one clock after the P-th consecutive such cycle.
- R2: After a bus-idle expiry the counter restarts from zero. While the condition persists, further expiries follow every P cycles.
- R3: With `auto_idle_en_i` high, a bus-idle expiry frees the bus (`bus_busy_o` = 0) and pulses `force_idle_o` high for one cycle. Both take effect on the same clock edge that sets `idle_flag_o`.
- R4: `start_i` marks the bus occupied on the next clock. `stop_i` or `abort_i` frees it on the next clock. When a free and a start request arrive in the same cycle, the free wins.
- R5: The clock-low counter advances in every cycle where the clock line is low, independent of the bus state. `clk_low_flag_o` rises one clock after the P-th consecutive low cycle and repeats every P cycles while the line stays low.
- R6: Either counter returns to zero on the cycle after its condition goes false, for example on a clock rise or when the bus is freed. A later count starts over from one.
- R7: A period of zero, or a cleared enable, stops the matching timeout from ever setting its flag. It also holds that counter at zero.
- R8: Each flag stays set until its clear input is strobed. If a set event and a clear strobe fall in the same cycle, the flag ends up set.
- R9: After the synchronous active-low reset, the bus is free, both flags are clear and `force_idle_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized clock-line level |
| start_i | input | 1 | Start-condition strobe, marks the bus occupied |
| stop_i | input | 1 | Stop-condition strobe, frees the bus |
| abort_i | input | 1 | Abort command, frees the bus |
| auto_idle_en_i | input | 1 | Free the bus automatically on a bus-idle timeout |
| idle_en_i | input | 1 | Bus-idle timeout enable |
| idle_period_i | input | CNT_W | Bus-idle period in cycles, 0 = off |
| low_en_i | input | 1 | Clock-low timeout enable |
| low_period_i | input | CNT_W | Clock-low period in cycles, 0 = off |
| clr_idle_flag_i | input | 1 | Write-one-to-clear strobe for the bus-idle flag |
| clr_low_flag_i | input | 1 | Write-one-to-clear strobe for the clock-low flag |
| bus_busy_o | output | 1 | Bus occupied state |
| idle_flag_o | output | 1 | Sticky bus-idle timeout flag |
| clk_low_flag_o | output | 1 | Sticky clock-low timeout flag |
| force_idle_o | output | 1 | One-cycle pulse to the controller on an auto-idle |

## Verification
The bench builds the block with `CNT_W` = 6, so the largest legal period is 63 cycles. This lets a directed phase run a full wrap at the top of the range and check that it repeats within a few hundred cycles. Periods of 1 are reachable too, which covers the case where a counter expires on every cycle. Zero periods are also exercised. A long random phase then mixes clock toggles, start, stop and abort strobes, clears and period changes. That phase catches same-cycle collisions between set and clear, and between start and free.

// File: rtl/i2c_tmo_pkg.sv
// Package: shared definitions for the bus timeout monitor.
// Assumes: included first in compile order.
package i2c_tmo_pkg;
    // Index of each timeout channel inside the monitor's arrays.
    localparam int TMO_IDLE = 0;
    localparam int TMO_LOW  = 1;
    localparam int TMO_NUM  = 2;

    // Bus occupancy as held by the monitor.
    typedef enum logic {
        BUS_FREE = 1'b0,
        BUS_HELD = 1'b1
    } bus_state_e;
endpackage

// File: rtl/tmo_counter.sv
// Module: tmo_counter
// Counts consecutive cycles while its condition holds. When the count reaches
// the period it raises expire_o for one cycle and restarts from zero.
// Assumes: period_i may change at any time. A period of zero or a low enable
// disables counting. If the period drops below the current count, the counter
// expires on the next active cycle.
module tmo_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] period_i,
    input  logic         cond_i,
    output logic         expire_o
);
    logic [W-1:0] cnt_q;
    logic         active;
    logic [W-1:0] last_val;

    // Decide whether this cycle counts and where the count tops out.
    always_comb begin
        active   = en_i && (period_i != '0) && cond_i;
        last_val = period_i - W'(1);
        expire_o = active && (cnt_q >= last_val);
    end

    // Advance, wrap on expiry, or clear when the condition drops.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (!active)  cnt_q <= '0;
        else if (expire_o) cnt_q <= '0;
        else               cnt_q <= cnt_q + W'(1);
    end

    // R6
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt_q == '0));

    // R7
    no_expire_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || period_i == '0) |-> !expire_o);
endmodule

// File: rtl/tmo_flag.sv
// Module: tmo_flag
// Sticky event flag, write-one-to-clear. A set in the same cycle as a clear
// leaves the flag set.
// Assumes: set_i and clr_i are single-cycle-qualified strobes on clk.
module tmo_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Hold the flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
endmodule

// File: rtl/i2c_tmo_monitor.sv
// Module: i2c_tmo_monitor (top)
// Holds the bus-occupied state and runs the bus-idle and clock-low timeouts.
// Each timeout drives a sticky flag. Optionally a bus-idle timeout frees the
// bus and pulses force_idle_o.
// Assumes: scl_i is already synchronized to clk. Start, stop and abort are
// one-cycle strobes.
module i2c_tmo_monitor
    import i2c_tmo_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             abort_i,
    input  logic             auto_idle_en_i,
    input  logic             idle_en_i,
    input  logic [CNT_W-1:0] idle_period_i,
    input  logic             low_en_i,
    input  logic [CNT_W-1:0] low_period_i,
    input  logic             clr_idle_flag_i,
    input  logic             clr_low_flag_i,
    output logic             bus_busy_o,
    output logic             idle_flag_o,
    output logic             clk_low_flag_o,
    output logic             force_idle_o
);
    bus_state_e             bus_q;
    logic                   force_now;
    logic                   free_req;
    logic [TMO_NUM-1:0]     ch_en;
    logic [TMO_NUM-1:0]     ch_cond;
    logic [TMO_NUM-1:0]     ch_exp;
    logic [TMO_NUM-1:0]     ch_clr;
    logic [TMO_NUM-1:0]     ch_flag;
    logic [CNT_W-1:0]       ch_period [TMO_NUM];

    // Route per-channel enables, periods, conditions and clears.
    always_comb begin
        ch_en[TMO_IDLE]     = idle_en_i;
        ch_en[TMO_LOW]      = low_en_i;
        ch_period[TMO_IDLE] = idle_period_i;
        ch_period[TMO_LOW]  = low_period_i;
        ch_cond[TMO_IDLE]   = (bus_q == BUS_HELD) && scl_i;
        ch_cond[TMO_LOW]    = !scl_i;
        ch_clr[TMO_IDLE]    = clr_idle_flag_i;
        ch_clr[TMO_LOW]     = clr_low_flag_i;
    end

    // One counter and one flag per timeout channel.
    for (genvar g = 0; g < TMO_NUM; g++) begin : g_ch
        tmo_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (ch_en[g]),
            .period_i (ch_period[g]),
            .cond_i   (ch_cond[g]),
            .expire_o (ch_exp[g])
        );
        tmo_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (ch_exp[g]),
            .clr_i  (ch_clr[g]),
            .flag_o (ch_flag[g])
        );
    end

    // Gather the requests that free the bus this cycle.
    always_comb begin
        force_now = auto_idle_en_i && ch_exp[TMO_IDLE];
        free_req  = stop_i || abort_i || force_now;
    end

    // Bus occupancy: a free request beats a start in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        bus_q <= BUS_FREE;
        else if (free_req) bus_q <= BUS_FREE;
        else if (start_i)  bus_q <= BUS_HELD;
    end

    // Register the force-idle pulse so it lines up with the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) force_idle_o <= 1'b0;
        else        force_idle_o <= force_now;
    end

    assign bus_busy_o     = (bus_q == BUS_HELD);
    assign idle_flag_o    = ch_flag[TMO_IDLE];
    assign clk_low_flag_o = ch_flag[TMO_LOW];

    // R4
    abort_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i || stop_i) |=> !bus_busy_o);

    // R3
    force_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_idle_o |-> (!bus_busy_o && idle_flag_o));

    // R1
    idle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_flag_o) |-> $past(bus_busy_o && scl_i && idle_en_i));

    // R5
    low_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_low_flag_o) |-> $past(!scl_i && low_en_i));
endmodule

// File: tb/i2c_tmo_monitor_bench.sv
// Bench: behavioural reference model updated on each rising edge and compared
// with the design at every falling edge.
module i2c_tmo_monitor_bench;
    localparam int CNT_W = 6;
    localparam int MAXP  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, start = 1'b0, stop = 1'b0, abort = 1'b0, auto_en = 1'b0;
    logic idle_en = 1'b0, low_en = 1'b0, clr_idle = 1'b0, clr_low = 1'b0;
    logic [CNT_W-1:0] idle_p = '0, low_p = '0;
    logic busy, iflag, lflag, fidle;

    int compared = 0, mismatched = 0;
    // Model state
    int  m_icnt = 0, m_lcnt = 0;
    bit  m_busy = 0, m_iflag = 0, m_lflag = 0, m_force = 0;

    always #2 clk = ~clk;

    i2c_tmo_monitor #(.CNT_W(CNT_W)) u_i2c_tmo_monitor (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .start_i(start), .stop_i(stop),
        .abort_i(abort), .auto_idle_en_i(auto_en), .idle_en_i(idle_en),
        .idle_period_i(idle_p), .low_en_i(low_en), .low_period_i(low_p),
        .clr_idle_flag_i(clr_idle), .clr_low_flag_i(clr_low),
        .bus_busy_o(busy), .idle_flag_o(iflag), .clk_low_flag_o(lflag),
        .force_idle_o(fidle));

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        bit ia, la, iexp, lexp;
        if (!rst_n) begin
            m_icnt = 0; m_lcnt = 0; m_busy = 0;
            m_iflag = 0; m_lflag = 0; m_force = 0;
        end else begin
            ia   = idle_en && (idle_p != 0) && m_busy && scl;
            la   = low_en && (low_p != 0) && !scl;
            iexp = ia && (m_icnt + 1 >= int'(idle_p));
            lexp = la && (m_lcnt + 1 >= int'(low_p));
            m_icnt = (!ia || iexp) ? 0 : m_icnt + 1;
            m_lcnt = (!la || lexp) ? 0 : m_lcnt + 1;
            if (iexp) m_iflag = 1; else if (clr_idle) m_iflag = 0;
            if (lexp) m_lflag = 1; else if (clr_low) m_lflag = 0;
            m_force = auto_en && iexp;
            if (stop || abort || m_force) m_busy = 0;
            else if (start) m_busy = 1;
        end
    end

    task automatic chk(input string tag, input logic act, input bit exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // Compare all outputs, then step the inputs for one cycle.
    task automatic step();
        @(negedge clk);
        chk("R4 R9 bus_busy", busy, m_busy);
        chk("R1 R2 R6 R7 R8 idle_flag", iflag, m_iflag);
        chk("R5 R6 R7 R8 clk_low_flag", lflag, m_lflag);
        chk("R3 force_idle", fidle, m_force);
        start = 0; stop = 0; abort = 0; clr_idle = 0; clr_low = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        run(3);                                  // R9 reset state
        rst_n = 1;
        idle_en = 1; idle_p = 5; low_en = 1; low_p = 3;
        run(2);
        start = 1; run(1);                       // R4 occupy
        run(22);                                 // R1 R2 periodic idle
        clr_idle = 1; run(1); run(6);            // R8 clear
        scl = 0; run(10);                        // R5 periodic low, R6 idle reset
        scl = 1; run(2); scl = 0; run(2); scl = 1; run(4); // R6 restart
        auto_en = 1; run(8);                     // R3 auto-idle
        auto_en = 0;
        start = 1; abort = 1; run(3);            // R4 free wins
        start = 1; run(3); stop = 1; run(3);
        start = 1; run(2); abort = 1; run(3);
        idle_p = 0; low_p = 0; start = 1; run(10); scl = 0; run(10); // R7
        idle_en = 0; low_en = 0; idle_p = 4; low_p = 4; run(10); scl = 1; run(10);
        idle_en = 1; low_en = 1; idle_p = 1; low_p = 1; run(6); scl = 0; run(6); scl = 1;
        idle_p = MAXP[CNT_W-1:0]; clr_idle = 1; run(140);  // max period wrap
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            chk("R4 R9 bus_busy", busy, m_busy);
            chk("R1 R2 R6 R7 R8 idle_flag", iflag, m_iflag);
            chk("R5 R6 R7 R8 clk_low_flag", lflag, m_lflag);
            chk("R3 force_idle", fidle, m_force);
            if ($urandom_range(0, 7) == 0) scl = ~scl;
            start    = ($urandom_range(0, 15) == 0);
            stop     = ($urandom_range(0, 40) == 0);
            abort    = ($urandom_range(0, 60) == 0);
            clr_idle = ($urandom_range(0, 5) == 0);
            clr_low  = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 200) == 0) auto_en = ~auto_en;
            if ($urandom_range(0, 300) == 0) idle_en = ~idle_en;
            if ($urandom_range(0, 300) == 0) low_en = ~low_en;
            if ($urandom_range(0, 150) == 0) idle_p = CNT_W'($urandom_range(0, 12));
            if ($urandom_range(0, 150) == 0) low_p  = CNT_W'($urandom_range(0, 12));
        end
        run(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule